// File: doc/BRIEF.md
# Raster Block-Transfer Engine with Raster Operations

This block moves rectangles of 16-bit pixels in a video memory that holds one pixel per address. All addresses and offsets are counted in pixel words. A host loads a rectangle description, picks one of three operations with a one-cycle start pulse, and then the engine walks the rectangle pixel by pixel and drives a single-port memory.

In the write operation the host pushes one pixel at a time through a 16-bit data port. For each pixel the engine reads the destination word, combines the host pixel with it through a 4-bit raster operation and writes the result back. In the read operation the host pulls source pixels through the same port. The negative move needs no host traffic. It copies a source rectangle onto a destination rectangle and combines each pixel through the raster operation. Within every row it runs from the right-hand column back to column 0.

Either side can use rectangular addressing, where rows are a fixed row offset apart, or linear addressing, where pixels are contiguous. The active and data-available status outputs tell the host when a transfer has finished.

Top module: `blit_engine`

## Requirements
- R1: Result bit i equals bit number {S[i],D[i]} of the 4-bit raster code, with S as the high index bit. So code 0 gives all zeros, 15 all ones, 12 gives S, 10 gives D, 8 gives S AND D, 14 gives S OR D, 6 gives S XOR D, 4 gives S AND NOT D, 7 gives NOT(S AND D) and 13 gives S OR NOT D.
- R2: A start pulse while the engine is idle is handled as follows:
  - With operation code 0 (write), 1 (read) or 3 (negative move), the engine raises `active` on the next cycle and resets its column and row counters.
  - Code 1 also raises `data_avail`.
  - Any other code leaves `active` low.
  - A start pulse while `active` is high is ignored.
- R3: In the write operation, each host write taken while `port_ready` is high reads the current destination word. It then writes back the raster result of the host pixel (as S) and that word (as D), at the same address.
- R4: In the read operation, a host read taken while `port_ready` is high returns the next source pixel, with `host_rvalid` three cycles after the request. A host read at any other accepted time returns 0, with `host_rvalid` on the next cycle.
- R5: Rectangular forward addressing starts at the base address and steps +1 within a row. After column `width_m1` it moves to the start of the row plus `row_offset`. Words between rows are left untouched.
- R6: Linear addressing steps +1 for every pixel, with no row rewind.
- R7: After (width_m1+1)×(height_m1+1) pixels, `active` and `data_avail` both fall and the engine returns to idle.
- R8: The negative move works row by row:
  - Rows advance by `row_offset`. Within a row, columns run from `width_m1` down to 0.
  - A linear side instead takes consecutive increasing addresses. The source and destination linear flags act independently.
  - Each pixel is a source read, a destination read and a destination write. There is never more than one memory access per cycle, and `active` stays high for the whole move.
- R9: Host writes are ignored, and the memory is not written, unless a write operation is active and `port_ready` is high. Host port requests are ignored while `port_ready` is low.
- R10: After reset, `active`, `data_avail`, `host_rvalid`, `vram_rd` and `vram_wr` are low and `port_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts an operation |
| op | input | 3 | Operation code: 0 write, 1 read, 3 negative move |
| rop | input | 4 | Raster operation code |
| src_base | input | AW | Source start address in pixel words |
| dst_base | input | AW | Destination start address in pixel words |
| width_m1 | input | DW | Rectangle width minus one |
| height_m1 | input | DW | Rectangle height minus one |
| row_offset | input | AW | Distance between row starts in pixel words |
| src_linear | input | 1 | Source uses linear addressing |
| dst_linear | input | 1 | Destination uses linear addressing |
| host_wr | input | 1 | Host pixel write strobe |
| host_wdata | input | PW | Host pixel to write |
| host_rd | input | 1 | Host pixel read request |
| host_rdata | output | PW | Returned pixel |
| host_rvalid | output | 1 | One-cycle strobe marking `host_rdata` valid |
| port_ready | output | 1 | Host data port can take a request |
| active | output | 1 | Operation in progress |
| data_avail | output | 1 | Read operation has pixels pending |
| vram_rd | output | 1 | Memory read strobe |
| vram_wr | output | 1 | Memory write strobe |
| vram_addr | output | AW | Memory word address |
| vram_wdata | output | PW | Memory write data |
| vram_rdata | input | PW | Memory read data, one cycle after `vram_rd` |

## Verification
The assertions guard the following rules on every cycle:
- Reads and writes never collide.
- Every memory write lands on the address read two cycles before it.
- `data_avail` never stands without `active`.
- `active` rises only after a start pulse.
- A move keeps `active` high.
- Non-read returns are zero.
- The column counters stay inside the width.

Only the directed scenarios can show the rest:
- The raster results themselves.
- The exact address walk for rectangular, linear and reverse-column traversal.
- Completion after the right pixel count.
- The fact that ignored host writes leave the memory unchanged.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_WRITE = 3'd0;
  localparam logic [OPW-1:0] OP_READ  = 3'd1;
  localparam logic [OPW-1:0] OP_MOVE  = 3'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_W_WAIT, ST_W_LAT, ST_W_MOD,
    ST_R_WAIT, ST_R_LAT, ST_R_OUT,
    ST_M_RS, ST_M_RD, ST_M_CAP, ST_M_WR
  } blit_state_t;
endpackage

// File: rtl/blit_rop.sv
module blit_rop #(
  parameter int PW = 16
) (
  input  logic [3:0]    code,
  input  logic [PW-1:0] s,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] res
);
  // each result bit selects one bit of the code, indexed by {S,D}
  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign res[i] = code[{s[i], d[i]}];
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int AW = 16,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic          linear,
  input  logic          reverse,
  input  logic [DW-1:0] wmax,
  input  logic [DW-1:0] hmax,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [DW-1:0] col, row, wmax_q, hmax_q;
  logic [AW-1:0] off_q;
  logic          lin_q, rev_q;

  assign last = (col == wmax_q) && (row == hmax_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0; row <= '0; addr <= '0;
      wmax_q <= '0; hmax_q <= '0; off_q <= '0;
      lin_q <= 1'b0; rev_q <= 1'b0;
    end else if (load) begin
      col <= '0; row <= '0;
      wmax_q <= wmax; hmax_q <= hmax; off_q <= offset;
      lin_q <= linear; rev_q <= reverse;
      addr <= (reverse && !linear) ? base + AW'(wmax) : base;
    end else if (step) begin
      if (col == wmax_q) begin
        col <= '0;
        row <= row + 1'b1;
        if (lin_q)      addr <= addr + 1'b1;
        else if (rev_q) addr <= addr + off_q + AW'(wmax_q);
        else            addr <= addr + off_q - AW'(wmax_q);
      end else begin
        col <= col + 1'b1;
        addr <= (rev_q && !lin_q) ? addr - 1'b1 : addr + 1'b1;
      end
    end
  end

  a_r5_col_in_range: assert property (@(posedge clk) disable iff (rst)
    col <= wmax_q);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 10,
  parameter int PW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic [3:0]     rop,
  input  logic [AW-1:0]  src_base,
  input  logic [AW-1:0]  dst_base,
  input  logic [DW-1:0]  width_m1,
  input  logic [DW-1:0]  height_m1,
  input  logic [AW-1:0]  row_offset,
  input  logic           src_linear,
  input  logic           dst_linear,
  input  logic           host_wr,
  input  logic [PW-1:0]  host_wdata,
  input  logic           host_rd,
  output logic [PW-1:0]  host_rdata,
  output logic           host_rvalid,
  output logic           port_ready,
  output logic           active,
  output logic           data_avail,
  output logic           vram_rd,
  output logic           vram_wr,
  output logic [AW-1:0]  vram_addr,
  output logic [PW-1:0]  vram_wdata,
  input  logic [PW-1:0]  vram_rdata
);
  blit_state_t    state;
  logic [OPW-1:0] op_q;
  logic [3:0]     rop_q;
  logic [PW-1:0]  pix_q, rop_res;
  logic [AW-1:0]  src_addr, dst_addr;
  logic           src_last, dst_last, src_step, dst_step, op_ok, start_ok;

  assign op_ok    = (op == OP_WRITE) || (op == OP_READ) || (op == OP_MOVE);
  assign start_ok = start && (state == ST_IDLE) && op_ok;
  assign src_step = ((state == ST_R_WAIT) && host_rd) || (state == ST_M_WR);
  assign dst_step = (state == ST_W_MOD) || (state == ST_M_WR);
  assign port_ready = (state == ST_IDLE) || (state == ST_W_WAIT) || (state == ST_R_WAIT);

  blit_walker #(.AW(AW), .DW(DW)) u_src_walk (
    .clk(clk), .rst(rst), .load(start_ok), .step(src_step),
    .base(src_base), .linear(src_linear), .reverse(op == OP_MOVE),
    .wmax(width_m1), .hmax(height_m1), .offset(row_offset),
    .addr(src_addr), .last(src_last));

  blit_walker #(.AW(AW), .DW(DW)) u_dst_walk (
    .clk(clk), .rst(rst), .load(start_ok), .step(dst_step),
    .base(dst_base), .linear(dst_linear), .reverse(op == OP_MOVE),
    .wmax(width_m1), .hmax(height_m1), .offset(row_offset),
    .addr(dst_addr), .last(dst_last));

  blit_rop #(.PW(PW)) u_rop (.code(rop_q), .s(pix_q), .d(vram_rdata), .res(rop_res));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; op_q <= OP_WRITE; rop_q <= '0; pix_q <= '0;
      active <= 1'b0; data_avail <= 1'b0;
      host_rdata <= '0; host_rvalid <= 1'b0;
      vram_rd <= 1'b0; vram_wr <= 1'b0; vram_addr <= '0; vram_wdata <= '0;
    end else begin
      vram_rd <= 1'b0;
      vram_wr <= 1'b0;
      host_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            op_q <= op; rop_q <= rop; active <= 1'b1;
            data_avail <= (op == OP_READ);
            state <= (op == OP_WRITE) ? ST_W_WAIT :
                     (op == OP_READ)  ? ST_R_WAIT : ST_M_RS;
          end else if (host_rd) begin
            host_rdata <= '0; host_rvalid <= 1'b1;
          end
        end
        ST_W_WAIT: begin
          if (host_wr) begin
            pix_q <= host_wdata; vram_rd <= 1'b1; vram_addr <= dst_addr;
            state <= ST_W_LAT;
          end else if (host_rd) begin
            host_rdata <= '0; host_rvalid <= 1'b1;
          end
        end
        ST_W_LAT: state <= ST_W_MOD;
        ST_W_MOD: begin
          vram_wr <= 1'b1; vram_wdata <= rop_res; vram_addr <= dst_addr;
          if (dst_last) begin active <= 1'b0; state <= ST_IDLE; end
          else state <= ST_W_WAIT;
        end
        ST_R_WAIT: begin
          if (host_rd) begin
            vram_rd <= 1'b1; vram_addr <= src_addr;
            if (src_last) begin active <= 1'b0; data_avail <= 1'b0; end
            state <= ST_R_LAT;
          end
        end
        ST_R_LAT: state <= ST_R_OUT;
        ST_R_OUT: begin
          host_rdata <= vram_rdata; host_rvalid <= 1'b1;
          state <= active ? ST_R_WAIT : ST_IDLE;
        end
        ST_M_RS: begin
          vram_rd <= 1'b1; vram_addr <= src_addr; state <= ST_M_RD;
        end
        ST_M_RD: begin
          vram_rd <= 1'b1; vram_addr <= dst_addr; state <= ST_M_CAP;
        end
        ST_M_CAP: begin
          pix_q <= vram_rdata; state <= ST_M_WR;
        end
        ST_M_WR: begin
          vram_wr <= 1'b1; vram_wdata <= rop_res; vram_addr <= dst_addr;
          if (dst_last) begin active <= 1'b0; state <= ST_IDLE; end
          else state <= ST_M_RS;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: one memory access per cycle at most
  a_r8_single_access: assert property (@(posedge clk) disable iff (rst)
    !(vram_rd && vram_wr));
  // R3: every write follows a read of the same word two cycles earlier
  a_r3_rmw_pairing: assert property (@(posedge clk) disable iff (rst)
    vram_wr |-> ($past(vram_rd, 2) && ($past(vram_addr, 2) == vram_addr)));
  // R2: data-available status only while active
  a_r2_avail_needs_active: assert property (@(posedge clk) disable iff (rst)
    data_avail |-> active);
  // R2: active only rises after a start pulse
  a_r2_active_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(start));
  // R8: a move holds active throughout
  a_r8_move_active: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_M_RS) || (state == ST_M_RD) || (state == ST_M_CAP) ||
     (state == ST_M_WR)) |-> active);
  // R4: returns outside a read operation carry zero
  a_r4_zero_return: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && (op_q != OP_READ)) |-> (host_rdata == '0));
endmodule

// File: tb/blit_engine_bench.sv
module blit_engine_bench;
  localparam int AW = 16;
  localparam int DW = 10;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic start = 0, src_linear = 0, dst_linear = 0, host_wr = 0, host_rd = 0;
  logic [2:0] op = 0;
  logic [3:0] rop = 0;
  logic [AW-1:0] src_base = 0, dst_base = 0, row_offset = 0;
  logic [DW-1:0] width_m1 = 0, height_m1 = 0;
  logic [PW-1:0] host_wdata = 0, host_rdata, vram_wdata, vram_rdata;
  logic host_rvalid, port_ready, active, data_avail, vram_rd, vram_wr;
  logic [AW-1:0] vram_addr;

  blit_engine #(.AW(AW), .DW(DW), .PW(PW)) u_blit_engine (
    .clk(clk), .rst(rst), .start(start), .op(op), .rop(rop),
    .src_base(src_base), .dst_base(dst_base), .width_m1(width_m1),
    .height_m1(height_m1), .row_offset(row_offset),
    .src_linear(src_linear), .dst_linear(dst_linear),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .port_ready(port_ready), .active(active), .data_avail(data_avail),
    .vram_rd(vram_rd), .vram_wr(vram_wr), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata));

  function automatic logic [15:0] pat(int i);
    return 16'((i * 40503) & 16'hffff) ^ 16'h5a5a;
  endfunction

  function automatic logic [15:0] exp_rop(logic [3:0] c, logic [15:0] s, logic [15:0] d);
    case (c)
      4'd0: return 16'h0000;      4'd1: return ~(s | d);
      4'd2: return ~s & d;        4'd3: return ~s;
      4'd4: return s & ~d;        4'd5: return ~d;
      4'd6: return s ^ d;         4'd7: return ~(s & d);
      4'd8: return s & d;         4'd9: return ~(s ^ d);
      4'd10: return d;            4'd11: return ~s | d;
      4'd12: return s;            4'd13: return s | ~d;
      4'd14: return s | d;        default: return 16'hffff;
    endcase
  endfunction

  // memory model: registered read, one cycle latency
  logic [15:0] mem [0:1023];
  logic mem_init = 0, log_clr = 0;
  logic [AW-1:0] wlog [0:15];
  int wcnt = 0;
  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else begin
      if (vram_wr) mem[vram_addr[9:0]] <= vram_wdata;
      if (vram_rd) vram_rdata <= mem[vram_addr[9:0]];
    end
    if (log_clr) wcnt <= 0;
    else if (vram_wr) begin
      wlog[wcnt[3:0]] <= vram_addr;
      wcnt <= wcnt + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(logic [2:0] o, logic [3:0] r, int s, int d, int w, int h,
                          int off, logic sl, logic dl);
    op = o; rop = r; src_base = AW'(s); dst_base = AW'(d);
    width_m1 = DW'(w); height_m1 = DW'(h); row_offset = AW'(off);
    src_linear = sl; dst_linear = dl; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 50 && !port_ready; k++) @(negedge clk);
  endtask

  task automatic host_write(logic [15:0] v);
    wait_ready();
    host_wr = 1; host_wdata = v;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic host_read(output logic [15:0] v);
    wait_ready();
    host_rd = 1;
    @(negedge clk); host_rd = 0;
    v = 16'hdead;
    for (int k = 0; k < 8; k++) begin
      if (host_rvalid) begin v = host_rdata; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && (active || !port_ready); k++) @(negedge clk);
    cyc(3);
  endtask

  task automatic clear_log();
    log_clr = 1; @(negedge clk); log_clr = 0;
  endtask

  task automatic t_reset();
    chk("R10 active", active, 0);
    chk("R10 data_avail", data_avail, 0);
    chk("R10 port_ready", port_ready, 1);
    chk("R10 host_rvalid", host_rvalid, 0);
    chk("R10 vram strobes", {vram_rd, vram_wr}, 0);
  endtask

  task automatic t_idle_read();
    logic [15:0] v;
    host_read(v);
    chk("R4 idle read zero", v, 0);
  endtask

  task automatic t_write_rect();
    do_start(3'd0, 4'd6, 0, 100, 2, 1, 10, 0, 0);
    chk("R2 write sets active", active, 1);
    chk("R2 write keeps data_avail low", data_avail, 0);
    for (int k = 0; k < 6; k++) begin
      host_write(16'h1111 * 16'(k) + 16'h0303);
      if (k == 4) chk("R7 active before last pixel", active, 1);
    end
    wait_idle();
    chk("R7 write done active", active, 0);
    for (int k = 0; k < 6; k++) begin
      int a = 100 + (k / 3) * 10 + (k % 3);
      chk("R3 R5 write rect", mem[a], exp_rop(4'd6, 16'h1111 * 16'(k) + 16'h0303, pat(a)));
    end
    chk("R5 gap untouched 103", mem[103], pat(103));
    chk("R5 gap untouched 109", mem[109], pat(109));
  endtask

  task automatic t_write_linear();
    do_start(3'd0, 4'd8, 0, 200, 1, 1, 50, 0, 1);
    for (int k = 0; k < 4; k++) host_write(16'hf0f0 ^ 16'(k * 257));
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk("R6 write linear", mem[200 + k], exp_rop(4'd8, 16'hf0f0 ^ 16'(k * 257), pat(200 + k)));
    chk("R6 linear end untouched", mem[204], pat(204));
  endtask

  task automatic t_read_rect();
    logic [15:0] v;
    do_start(3'd1, 4'd0, 300, 0, 1, 2, 5, 0, 0);
    chk("R2 read sets data_avail", data_avail, 1);
    for (int k = 0; k < 6; k++) begin
      host_read(v);
      chk("R4 R5 read rect", v, pat(300 + (k / 2) * 5 + (k % 2)));
    end
    wait_idle();
    chk("R7 read done data_avail", data_avail, 0);
    chk("R7 read done active", active, 0);
  endtask

  task automatic t_move_rect();
    clear_log();
    do_start(3'd3, 4'd12, 400, 500, 2, 1, 8, 0, 0);
    chk("R2 move sets active", active, 1);
    cyc(10);
    chk("R8 active during move", active, 1);
    wait_idle();
    chk("R8 move write count", wcnt, 6);
    for (int k = 0; k < 6; k++) begin
      int x = 2 - (k % 3), y = k / 3;
      chk("R8 move reverse order", wlog[k], 500 + y * 8 + x);
      chk("R8 move data", mem[500 + y * 8 + x], pat(400 + y * 8 + x));
    end
  endtask

  task automatic t_move_linear_src();
    int dst_order[4] = '{601, 600, 609, 608};
    clear_log();
    do_start(3'd3, 4'd4, 700, 600, 1, 1, 8, 1, 0);
    wait_idle();
    for (int k = 0; k < 4; k++) begin
      chk("R8 move linear src order", wlog[k], dst_order[k]);
      chk("R8 R1 move and-not", mem[dst_order[k]],
          exp_rop(4'd4, pat(700 + k), pat(dst_order[k])));
    end
  endtask

  task automatic t_unknown_op();
    logic [15:0] v;
    clear_log();
    do_start(3'd2, 4'd15, 0, 800, 0, 0, 0, 0, 0);
    chk("R2 code 2 stays idle", active, 0);
    do_start(3'd7, 4'd15, 0, 800, 0, 0, 0, 0, 0);
    chk("R2 code 7 stays idle", active, 0);
    host_write(16'hffff);
    cyc(4);
    chk("R9 idle write no memory write", wcnt, 0);
    chk("R9 idle write memory unchanged", mem[800], pat(800));
    host_read(v);
    chk("R4 read while idle", v, 0);
  endtask

  task automatic t_cross();
    logic [15:0] v;
    do_start(3'd0, 4'd14, 0, 820, 0, 0, 0, 0, 0);
    do_start(3'd1, 4'd0, 830, 0, 0, 0, 0, 0, 0);
    chk("R2 start ignored while active", data_avail, 0);
    host_read(v);
    chk("R4 read during write op", v, 0);
    host_write(16'h00f0);
    wait_idle();
    chk("R3 write after ignored start", mem[820], exp_rop(4'd14, 16'h00f0, pat(820)));
    clear_log();
    do_start(3'd1, 4'd0, 830, 840, 0, 0, 0, 0, 0);
    host_write(16'h1234);
    cyc(4);
    chk("R9 write during read op", wcnt, 0);
    chk("R9 read op still pending", data_avail, 1);
    host_read(v);
    chk("R4 read single pixel", v, pat(830));
    wait_idle();
  endtask

  task automatic t_rops();
    logic [3:0] codes[8] = '{4'd0, 4'd1, 4'd7, 4'd9, 4'd13, 4'd15, 4'd2, 4'd11};
    for (int i = 0; i < 8; i++) begin
      do_start(3'd0, codes[i], 0, 900 + i, 0, 0, 0, 0, 0);
      host_write(16'hc3a5);
      wait_idle();
      chk("R1 raster code", mem[900 + i], exp_rop(codes[i], 16'hc3a5, pat(900 + i)));
    end
  endtask

  initial begin
    fork
      begin
        mem_init = 1;
        cyc(3);
        mem_init = 0;
        rst = 0;
        cyc(2);
        t_reset();
        t_idle_read();
        t_write_rect();
        t_write_linear();
        t_read_rect();
        t_move_rect();
        t_move_linear_src();
        t_unknown_op();
        t_cross();
        t_rops();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule